// File: doc/BRIEF.md
# Cache Line Write-Back Buffer

This block holds a single dirty line that an operand cache evicts on a write-back replacement. The cache controller hands over the whole line in one cycle: four 32-bit words and the line address (byte-address bits 31..4). The controller then fetches the replacement line over the external bus. The buffer does not compete with that refill. It stays quiet until the controller signals that the fill has finished, and only then writes the four words out through a request/grant write port.

The cache keeps serving hits while the buffer drains. Only a second eviction has to wait: the load port has a ready signal, and it stays low from the moment a line is captured until memory accepts the last word of that line. The address driven to memory always has its three most significant bits cleared, so the buffer keeps just the 25 line-address bits it actually drives.

Top module: `wb_line_buffer`

## Requirements
- R1: After reset, `ld_ready_o` is 1 and `mem_req_o` is 0.
- R2: A line is captured on a clock edge where `ld_valid_i` and `ld_ready_o` are both 1. After that edge `ld_ready_o` is 0 until the line has fully drained. A load offered while `ld_ready_o` is 0 is ignored and does not alter the buffered address or words.
- R3: After a load, `mem_req_o` stays 0 until `fill_done_i` is seen. A `fill_done_i` pulse while the buffer is empty has no effect.
- R4: A `fill_done_i` given in the same cycle as an accepted load counts as the fill completion, so `mem_req_o` is 1 in the very next cycle.
- R5: When `fill_done_i` is seen while a line waits, `mem_req_o` is 1 from the next cycle on.
- R6: The write address is {3'b000, line address bits 24..0, word index (2 bits), 2'b00}. Bits 27..25 of `ld_addr_i` are dropped.
- R7: The words go out in ascending index order, 0 to 3. Word k is `ld_data_i[32k+31:32k]`.
- R8: While `mem_req_o` is 1 and `mem_gnt_i` is 0, the request, `mem_addr_o` and `mem_wdata_o` stay unchanged in the next cycle.
- R9: After the edge on which the word with index 3 is granted, `mem_req_o` is 0 and `ld_ready_o` is 1.
- R10: In the cycle in which word 3 is granted, `ld_ready_o` is still 0, so a new load offered in that cycle is held off by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Cache offers an evicted dirty line |
| ld_ready_o | output | 1 | Buffer empty, load accepted |
| ld_addr_i | input | 28 | Line address, byte-address bits 31..4 |
| ld_data_i | input | 128 | Line data, word k in bits 32k+31..32k |
| fill_done_i | input | 1 | Replacement line fill finished |
| mem_req_o | output | 1 | External write request |
| mem_gnt_i | input | 1 | Memory accepts the current word |
| mem_addr_o | output | 32 | Byte address of the current word |
| mem_wdata_o | output | 32 | Current word |

## Verification
Two pairs of events can land in the same cycle:
- **Load and fill completion.** The bench offers a load and pulses `fill_done_i` in the same cycle. It then expects the write request in the very next cycle, with no wait state in between.
- **Final grant and new load.** The bench grants the last word while a new line is already being offered. It expects `ld_ready_o` to be low in that cycle. One cycle later the request must drop and the load must be taken. The bench then confirms this by draining that second line and comparing every address and word.

// File: rtl/wb_line_buffer_pkg.sv
package wb_line_buffer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_FILL = 2'd1,
    ST_DRAIN     = 2'd2
  } wb_state_e;
endpackage

// File: rtl/wb_line_store.sv
module wb_line_store #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int KEEP_W = 25,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    load_i,
  input  logic [KEEP_W-1:0]       line_addr_i,
  input  logic [WORDS*WORD_W-1:0] line_data_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [KEEP_W-1:0]       keep_addr_o,
  output logic [WORD_W-1:0]       word_o
);
  logic [WORD_W-1:0] word_q [WORDS];
  logic [KEEP_W-1:0] addr_q;

  // data path carries no reset: contents are only read while a line is held
  always_ff @(posedge clk_i) begin
    if (load_i) addr_q <= line_addr_i;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (load_i) word_q[g] <= line_data_i[g*WORD_W +: WORD_W];
    end
  end

  assign keep_addr_o = addr_q;
  assign word_o      = word_q[idx_i];
endmodule

// File: rtl/wb_drain_fsm.sv
module wb_drain_fsm
  import wb_line_buffer_pkg::*;
#(
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             fill_done_i,
  input  logic             gnt_i,
  output logic             ready_o,
  output logic             req_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  wb_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        idx_d = '0;
        if (load_i) state_d = fill_done_i ? ST_DRAIN : ST_WAIT_FILL;
      end
      ST_WAIT_FILL: if (fill_done_i) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (gnt_i) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign req_o   = (state_q == ST_DRAIN);
  assign idx_o   = idx_q;
endmodule

// File: rtl/wb_line_buffer.sv
module wb_line_buffer #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int WORDS     = 4,
  parameter int ZERO_MSBS = 3,
  localparam int BYTE_OFF_W  = $clog2(WORD_W / 8),
  localparam int IDX_W       = $clog2(WORDS),
  localparam int LINE_OFF_W  = BYTE_OFF_W + IDX_W,
  localparam int LINE_ADDR_W = ADDR_W - LINE_OFF_W,
  localparam int KEEP_W      = LINE_ADDR_W - ZERO_MSBS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_valid_i,
  output logic                    ld_ready_o,
  input  logic [LINE_ADDR_W-1:0]  ld_addr_i,
  input  logic [WORDS*WORD_W-1:0] ld_data_i,
  input  logic                    fill_done_i,
  output logic                    mem_req_o,
  input  logic                    mem_gnt_i,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [WORD_W-1:0]       mem_wdata_o
);
  logic             load;
  logic [IDX_W-1:0] idx;
  logic [KEEP_W-1:0] keep_addr;
  logic [ZERO_MSBS-1:0] dropped_msbs;

  assign load         = ld_valid_i & ld_ready_o;
  assign dropped_msbs = ld_addr_i[LINE_ADDR_W-1 -: ZERO_MSBS];

  wb_drain_fsm #(.WORDS(WORDS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .fill_done_i (fill_done_i),
    .gnt_i       (mem_gnt_i),
    .ready_o     (ld_ready_o),
    .req_o       (mem_req_o),
    .idx_o       (idx)
  );

  wb_line_store #(.WORD_W(WORD_W), .WORDS(WORDS), .KEEP_W(KEEP_W)) u_store (
    .clk_i       (clk_i),
    .load_i      (load),
    .line_addr_i (ld_addr_i[KEEP_W-1:0]),
    .line_data_i (ld_data_i),
    .idx_i       (idx),
    .keep_addr_o (keep_addr),
    .word_o      (mem_wdata_o)
  );

  // upper line-address bits are never driven to memory
  logic unused_msbs;
  assign unused_msbs = ^dropped_msbs;

  assign mem_addr_o = {{ZERO_MSBS{1'b0}}, keep_addr, idx, {BYTE_OFF_W{1'b0}}};
endmodule

// File: rtl/wb_line_buffer_chk.sv
module wb_line_buffer_chk #(
  parameter int ADDR_W    = 32,
  parameter int WORD_W    = 32,
  parameter int WORDS     = 4,
  parameter int ZERO_MSBS = 3,
  localparam int BYTE_OFF_W = $clog2(WORD_W / 8),
  localparam int IDX_W      = $clog2(WORDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_valid_i,
  input logic              ld_ready_o,
  input logic              fill_done_i,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0] idx_now;
  assign idx_now = mem_addr_o[BYTE_OFF_W +: IDX_W];

  a_r2_no_req_while_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ready_o |-> !mem_req_o);

  a_r2_busy_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && ld_ready_o |=> !ld_ready_o);

  a_r3_wait_for_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i && ld_ready_o && !fill_done_i |=> !mem_req_o);

  a_r6_addr_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[ADDR_W-1 -: ZERO_MSBS] == '0) &&
                  (mem_addr_o[BYTE_OFF_W-1:0] == '0));

  a_r7_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && idx_now != LAST_IDX |=>
      mem_req_o && idx_now == $past(idx_now) + 1'b1);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=>
      mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i && idx_now == LAST_IDX |=> ld_ready_o && !mem_req_o);
endmodule

bind wb_line_buffer wb_line_buffer_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .ZERO_MSBS(ZERO_MSBS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_valid_i  (ld_valid_i),
  .ld_ready_o  (ld_ready_o),
  .fill_done_i (fill_done_i),
  .mem_req_o   (mem_req_o),
  .mem_gnt_i   (mem_gnt_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/wb_line_buffer_tb_top.sv
module wb_line_buffer_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ld_valid_i = 1'b0;
  logic         ld_ready_o;
  logic [27:0]  ld_addr_i = '0;
  logic [127:0] ld_data_i = '0;
  logic         fill_done_i = 1'b0;
  logic         mem_req_o;
  logic         mem_gnt_i = 1'b0;
  logic [31:0]  mem_addr_o;
  logic [31:0]  mem_wdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  wb_line_buffer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_valid_i(ld_valid_i), .ld_ready_o(ld_ready_o),
    .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i), .fill_done_i(fill_done_i),
    .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [27:0] la, input int k);
    return {3'b000, la[24:0], k[1:0], 2'b00};
  endfunction

  // drains one line; wait_n idle cycles before each grant; optional load on last grant
  task automatic drain(input logic [27:0] la, input logic [127:0] d, input int wait_n,
                       input bit load_on_last, input logic [27:0] nla,
                       input logic [127:0] nd);
    for (int k = 0; k < 4; k++) begin
      for (int w = 0; w < wait_n; w++) begin
        mem_gnt_i = 1'b0;
        #0;
        chk(mem_req_o == 1'b1, "R8 req held", 128'(mem_req_o), 1);
        chk(mem_addr_o == exp_addr(la, k), "R8 addr held", 128'(mem_addr_o), 128'(exp_addr(la, k)));
        @(negedge clk_i);
      end
      mem_gnt_i = 1'b1;
      #0;
      chk(mem_req_o == 1'b1, "R7 req", 128'(mem_req_o), 1);
      chk(mem_addr_o == exp_addr(la, k), "R6 addr", 128'(mem_addr_o), 128'(exp_addr(la, k)));
      chk(mem_wdata_o == d[32*k +: 32], "R7 word", 128'(mem_wdata_o), 128'(d[32*k +: 32]));
      if (k == 3 && load_on_last) begin
        ld_valid_i = 1'b1; ld_addr_i = nla; ld_data_i = nd;
        #0;
        chk(ld_ready_o == 1'b0, "R10 ready low on last grant", 128'(ld_ready_o), 0);
      end
      @(negedge clk_i);
      mem_gnt_i = 1'b0;
    end
    #0;
    chk(mem_req_o == 1'b0, "R9 req drops", 128'(mem_req_o), 0);
    chk(ld_ready_o == 1'b1, "R9 ready back", 128'(ld_ready_o), 1);
  endtask

  task automatic t_reset();
    chk(ld_ready_o == 1'b1, "R1 ready", 128'(ld_ready_o), 1);
    chk(mem_req_o == 1'b0, "R1 req", 128'(mem_req_o), 0);
  endtask

  task automatic t_basic();
    logic [27:0]  la = 28'h0ABCDE1;
    logic [127:0] d  = 128'h44444444_33333333_22222222_11111111;
    ld_valid_i = 1'b1; ld_addr_i = la; ld_data_i = d;
    @(negedge clk_i);
    // offer a different line while full: must be ignored
    ld_addr_i = 28'h1234567; ld_data_i = '1;
    #0;
    chk(ld_ready_o == 1'b0, "R2 busy after load", 128'(ld_ready_o), 0);
    chk(mem_req_o == 1'b0, "R3 no req before fill", 128'(mem_req_o), 0);
    for (int i = 0; i < 3; i++) @(negedge clk_i);
    ld_valid_i = 1'b0;
    chk(mem_req_o == 1'b0, "R3 still waiting", 128'(mem_req_o), 0);
    fill_done_i = 1'b1;
    @(negedge clk_i);
    fill_done_i = 1'b0;
    #0;
    chk(mem_req_o == 1'b1, "R5 req after fill", 128'(mem_req_o), 1);
    drain(la, d, 0, 1'b0, '0, '0);
  endtask

  task automatic t_idle_fill();
    logic [27:0]  la = 28'h5555555;
    logic [127:0] d  = 128'hDEADBEEF_CAFEF00D_01234567_89ABCDEF;
    fill_done_i = 1'b1;
    @(negedge clk_i);
    fill_done_i = 1'b0;
    ld_valid_i = 1'b1; ld_addr_i = la; ld_data_i = d;
    @(negedge clk_i);
    ld_valid_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(mem_req_o == 1'b0, "R3 idle fill ignored", 128'(mem_req_o), 0);
      @(negedge clk_i);
    end
    fill_done_i = 1'b1;
    @(negedge clk_i);
    fill_done_i = 1'b0;
    drain(la, d, 2, 1'b0, '0, '0);
  endtask

  task automatic t_same_cycle();
    logic [27:0]  la  = 28'hFFFFFF0;
    logic [127:0] d   = 128'hA0A0A0A0_B1B1B1B1_C2C2C2C2_D3D3D3D3;
    logic [27:0]  la2 = 28'hE000003;
    logic [127:0] d2  = 128'h0F0F0F0F_F0F0F0F0_12121212_34343434;
    ld_valid_i = 1'b1; ld_addr_i = la; ld_data_i = d; fill_done_i = 1'b1;
    @(negedge clk_i);
    ld_valid_i = 1'b0; fill_done_i = 1'b0;
    #0;
    chk(mem_req_o == 1'b1, "R4 req next cycle", 128'(mem_req_o), 1);
    drain(la, d, 1, 1'b1, la2, d2);
    // the load held off during the last grant is taken now
    @(negedge clk_i);
    ld_valid_i = 1'b0;
    #0;
    chk(ld_ready_o == 1'b0, "R10 deferred load taken", 128'(ld_ready_o), 0);
    fill_done_i = 1'b1;
    @(negedge clk_i);
    fill_done_i = 1'b0;
    drain(la2, d2, 0, 1'b0, '0, '0);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    @(negedge clk_i);
    t_idle_fill();
    @(negedge clk_i);
    t_same_cycle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule